// File: doc/BRIEF.md
# Buffered Input-Capture Timer Channel

This block is one channel of a general-purpose timer. A 16-bit up-counter advances on a prescaler tick and records the time of events seen on two capture pins. An event on the first pin (A) stores the counter value in the primary capture register. In the same clock, the value that register held before moves into a secondary buffer register. Software therefore always sees the two most recent event times, and their difference gives a period or pulse width without any intervening read.

An event on the second pin (B) restarts the counter from zero. This lets the count measure time since a reference edge. Each pin has its own edge selection and its own sticky capture flag, which is cleared with a write-one-to-clear pulse. The counter raises a sticky overflow flag each time it wraps. Both capture inputs are assumed to come from outside the clock domain, so each passes through a two-flop synchronizer before edge detection.

A typical setup measures pin A on both edges and pin B on falling edges only. Both selections can be changed at any time.

Top module: `capture_timer_ch`

## Requirements
- R1: When reset is low at a clock edge, the counter, primary register, buffer register, both capture flags and the overflow flag all become zero.
- R2: The counter increases by one on every clock where the tick input is high, and holds its value when the tick is low.
- R3: A tick with the counter at 0xFFFF wraps it to 0x0000 and sets the overflow flag. The flag stays set until a clock where the overflow clear input is high and no new wrap occurs.
- R4: A capture on pin A loads the current counter value into the primary register. In the same clock, it moves the previous primary value into the buffer register.
- R5: A capture on pin B clears the counter to zero. When a tick arrives in that same clock, the clear takes priority.
- R6: When captures on A and B occur in the same clock, the primary register receives the counter value from before the clear, and the counter becomes zero.
- R7: Each pin has a 2-bit edge selection: 00 captures rising edges, 01 captures falling edges, and 10 or 11 captures both. An edge that is not selected changes neither the registers, the counter nor the flags.
- R8: A level change on a capture pin takes effect at the third rising clock edge after it. Two clocks are spent in the synchronizer, and the third clock performs the capture.
- R9: Each pin sets its own sticky capture flag on a capture, and a clear pulse for that pin resets it. When a capture and a clear fall in the same clock, the flag remains set.
- R10: Without a pin A capture, the primary and buffer registers keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_tick | input | 1 | Prescaler count enable, one clock per count |
| cap_a_in | input | 1 | Capture pin A (asynchronous) |
| cap_b_in | input | 1 | Capture pin B (asynchronous) |
| edge_sel_a | input | 2 | Pin A edge selection (00 rise, 01 fall, 1x both) |
| edge_sel_b | input | 2 | Pin B edge selection (00 rise, 01 fall, 1x both) |
| flag_a_clr | input | 1 | Write-one-to-clear for the pin A flag |
| flag_b_clr | input | 1 | Write-one-to-clear for the pin B flag |
| ovf_clr | input | 1 | Write-one-to-clear for the overflow flag |
| count | output | 16 | Current counter value |
| reg_a | output | 16 | Primary capture register |
| reg_c | output | 16 | Buffer register holding the previous capture |
| flag_a | output | 1 | Sticky capture flag for pin A |
| flag_b | output | 1 | Sticky capture flag for pin B |
| ovf_flag | output | 1 | Sticky counter overflow flag |

## Verification
Assertions check four rules on every clock:
- the counter steps by one, holds, wraps or clears as its inputs dictate;
- a pin A capture moves the old primary value into the buffer while loading the counter;
- both registers stay put when no capture occurs;
- every capture sets its flag.

Edge selection, the three-clock latency from a pin change, the priority of a clear over a tick, and the simultaneous A/B ordering all depend on the exact timing of the pin stimulus. These can only be shown by the bench's directed scenarios. The same holds for a flag clear colliding with a new capture and for a full wrap from 0xFFFF.

// File: rtl/cap_tmr_pkg.sv
// Package: shared codes and helpers for the capture timer channel.
// Assumes edge selection is a 2-bit field where bit 1 means "both edges".
package cap_tmr_pkg;
    localparam int CNT_W = 16;
    localparam int SEL_W = 2;

    localparam logic [SEL_W-1:0] SEL_RISE = 2'b00;
    localparam logic [SEL_W-1:0] SEL_FALL = 2'b01;

    // Decide whether an observed transition is one the selection asks for.
    function automatic logic edge_hit(input logic [SEL_W-1:0] sel,
                                      input logic rose, input logic fell);
        if (sel[1])              edge_hit = rose | fell;
        else if (sel == SEL_FALL) edge_hit = fell;
        else                     edge_hit = rose;
    endfunction
endpackage

// File: rtl/cap_edge_det.sv
// Synchronizes one asynchronous capture pin and flags the selected edges.
// Assumes the pin is held low during reset; the output is a one-clock pulse
// registered-free (combinational from the last two synchronized samples).
module cap_edge_det
    import cap_tmr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin,
    input  logic [SEL_W-1:0] sel,
    output logic             event_o
);
    logic [SYNC_STAGES-1:0] chain;
    logic                   prev;

    // Metastability chain: stage 0 samples the pin, later stages refine it.
    genvar gi;
    generate
        for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
            always_ff @(posedge clk) begin
                if (!rst_n)      chain[gi] <= 1'b0;
                else if (gi == 0) chain[gi] <= pin;
                else             chain[gi] <= chain[(gi == 0) ? 0 : gi-1];
            end
        end
    endgenerate

    // History flop holding the previous synchronized sample.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= chain[SYNC_STAGES-1];
    end

    // Compare current and previous sample against the selected edge kind.
    always_comb begin
        event_o = edge_hit(sel, chain[SYNC_STAGES-1] & ~prev,
                                ~chain[SYNC_STAGES-1] & prev);
    end
endmodule

// File: rtl/cap_counter.sv
// Free-running up-counter with synchronous clear and sticky wrap flag.
// Assumes clear outranks the tick; the wrap flag's clear loses to a new wrap.
module cap_counter
    import cap_tmr_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         clr,
    input  logic         ovf_clr,
    output logic [W-1:0] cnt,
    output logic         ovf
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};
    localparam logic [W-1:0] CNT_ONE = {{(W-1){1'b0}}, 1'b1};

    logic wrap;

    // A wrap is a tick taken at full scale that the clear did not preempt.
    always_comb wrap = tick && !clr && (cnt == CNT_MAX);

    // Count register: clear first, then tick, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (clr)  cnt <= '0;
        else if (tick) cnt <= cnt + CNT_ONE;
    end

    // Sticky overflow flag with write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       ovf <= 1'b0;
        else if (wrap)    ovf <= 1'b1;
        else if (ovf_clr) ovf <= 1'b0;
    end

    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clr && cnt != CNT_MAX) |=> (cnt == $past(cnt) + CNT_ONE));
    assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clr) |=> $stable(cnt));
    assert_clear_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));
    assert_wrap_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clr && cnt == CNT_MAX) |=> (cnt == '0 && ovf));
endmodule

// File: rtl/cap_regs.sv
// Primary capture register, its one-deep buffer, and the two capture flags.
// Assumes capture events are single-clock pulses; set outranks flag clear.
module cap_regs
    import cap_tmr_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap_a,
    input  logic         cap_b,
    input  logic [W-1:0] cnt_in,
    input  logic         clr_a,
    input  logic         clr_b,
    output logic [W-1:0] reg_a,
    output logic [W-1:0] reg_c,
    output logic         flag_a,
    output logic         flag_b
);
    // Capture shift: counter into primary, old primary into buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_a <= '0;
            reg_c <= '0;
        end else if (cap_a) begin
            reg_a <= cnt_in;
            reg_c <= reg_a;
        end
    end

    // Sticky pin A flag, set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)     flag_a <= 1'b0;
        else if (cap_a) flag_a <= 1'b1;
        else if (clr_a) flag_a <= 1'b0;
    end

    // Sticky pin B flag, set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)     flag_b <= 1'b0;
        else if (cap_b) flag_b <= 1'b1;
        else if (clr_b) flag_b <= 1'b0;
    end

    assert_buffer_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cap_a |=> (reg_a == $past(cnt_in) && reg_c == $past(reg_a)));
    assert_regs_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_a |=> ($stable(reg_a) && $stable(reg_c)));
    assert_flag_a_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cap_a |=> flag_a);
    assert_flag_b_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cap_b |=> flag_b);
endmodule

// File: rtl/capture_timer_ch.sv
// Top of one buffered input-capture timer channel.
// Wires two pin edge detectors, the counter and the capture register bank.
// Assumes pins are asynchronous and the tick is already in this clock domain.
module capture_timer_ch
    import cap_tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_tick,
    input  logic              cap_a_in,
    input  logic              cap_b_in,
    input  logic [1:0]        edge_sel_a,
    input  logic [1:0]        edge_sel_b,
    input  logic              flag_a_clr,
    input  logic              flag_b_clr,
    input  logic              ovf_clr,
    output logic [15:0]       count,
    output logic [15:0]       reg_a,
    output logic [15:0]       reg_c,
    output logic              flag_a,
    output logic              flag_b,
    output logic              ovf_flag
);
    localparam int NPIN = 2;

    logic [NPIN-1:0]       pins;
    logic [NPIN-1:0][1:0]  sels;
    logic [NPIN-1:0]       hits;

    always_comb begin
        pins = {cap_b_in, cap_a_in};
        sels = {edge_sel_b, edge_sel_a};
    end

    // One synchronizer and edge detector per capture pin.
    genvar gp;
    generate
        for (gp = 0; gp < NPIN; gp++) begin : g_pin
            cap_edge_det #(.SYNC_STAGES(2)) u_edge (
                .clk     (clk),
                .rst_n   (rst_n),
                .pin     (pins[gp]),
                .sel     (sels[gp]),
                .event_o (hits[gp])
            );
        end
    endgenerate

    cap_counter #(.W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (cnt_tick),
        .clr     (hits[1]),
        .ovf_clr (ovf_clr),
        .cnt     (count),
        .ovf     (ovf_flag)
    );

    cap_regs #(.W(CNT_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_a  (hits[0]),
        .cap_b  (hits[1]),
        .cnt_in (count),
        .clr_a  (flag_a_clr),
        .clr_b  (flag_b_clr),
        .reg_a  (reg_a),
        .reg_c  (reg_c),
        .flag_a (flag_a),
        .flag_b (flag_b)
    );

    assert_joint_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hits[0] && hits[1]) |=> (reg_a == $past(count) && count == 16'd0));
endmodule

// File: tb/capture_timer_ch_tb.sv
module capture_timer_ch_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_tick = 1'b0;
    logic        cap_a_in = 1'b0;
    logic        cap_b_in = 1'b0;
    logic [1:0]  edge_sel_a = 2'b00;
    logic [1:0]  edge_sel_b = 2'b01;
    logic        flag_a_clr = 1'b0;
    logic        flag_b_clr = 1'b0;
    logic        ovf_clr = 1'b0;
    logic [15:0] count, reg_a, reg_c;
    logic        flag_a, flag_b, ovf_flag;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    capture_timer_ch u_dut (
        .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick),
        .cap_a_in(cap_a_in), .cap_b_in(cap_b_in),
        .edge_sel_a(edge_sel_a), .edge_sel_b(edge_sel_b),
        .flag_a_clr(flag_a_clr), .flag_b_clr(flag_b_clr), .ovf_clr(ovf_clr),
        .count(count), .reg_a(reg_a), .reg_c(reg_c),
        .flag_a(flag_a), .flag_b(flag_b), .ovf_flag(ovf_flag)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Advance n clocks, ending at a falling edge.
    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cnt_tick = 0; cap_a_in = 0; cap_b_in = 0;
        cycles(3);
        rst_n = 1'b1;
    endtask

    task automatic run_ticks(input int n);
        cnt_tick = 1'b1;
        cycles(n);
        cnt_tick = 1'b0;
    endtask

    // Change pin A at a falling edge and wait out the synchronizer (R8).
    task automatic move_a(input logic v, input bit clr_same);
        cap_a_in = v;
        cycles(2);
        if (clr_same) flag_a_clr = 1'b1;
        cycles(1);
        flag_a_clr = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check(count == 0 && reg_a == 0 && reg_c == 0, "R1 regs", {count, reg_a}, 0);
        check(!flag_a && !flag_b && !ovf_flag, "R1 flags", {flag_a, flag_b, ovf_flag}, 0);
    endtask

    task automatic t_count();
        run_ticks(10);
        check(count == 16'd10, "R2 increment", count, 10);
        cycles(4);
        check(count == 16'd10, "R2 hold", count, 10);
    endtask

    task automatic t_latency();
        edge_sel_a = 2'b00;
        cap_a_in = 1'b1;
        cycles(2);
        check(reg_a == 0 && !flag_a, "R8 not before third edge", reg_a, 0);
        cycles(1);
        check(reg_a == 16'd10, "R8/R4 capture at third edge", reg_a, 10);
        check(reg_c == 16'd0, "R4 buffer old value", reg_c, 0);
        check(flag_a, "R9 flag set", flag_a, 1);
    endtask

    task automatic t_edge_select();
        run_ticks(5);
        move_a(1'b0, 0);
        check(reg_a == 16'd10 && reg_c == 0, "R7 falling ignored in rise mode", reg_a, 10);
        check(count == 16'd15, "R10 counter untouched", count, 15);
        edge_sel_a = 2'b01;
        move_a(1'b1, 0);
        check(reg_a == 16'd10, "R7 rising ignored in fall mode", reg_a, 10);
        run_ticks(3);
        move_a(1'b0, 0);
        check(reg_a == 16'd18 && reg_c == 16'd10, "R7/R4 falling capture",
              {reg_a, reg_c}, {16'd18, 16'd10});
        edge_sel_a = 2'b10;
        run_ticks(2);
        move_a(1'b1, 0);
        check(reg_a == 16'd20 && reg_c == 16'd18, "R7 both mode rise",
              {reg_a, reg_c}, {16'd20, 16'd18});
        edge_sel_a = 2'b11;
        run_ticks(1);
        move_a(1'b0, 0);
        check(reg_a == 16'd21 && reg_c == 16'd20, "R7 both mode fall",
              {reg_a, reg_c}, {16'd21, 16'd20});
    endtask

    task automatic t_flags();
        flag_a_clr = 1'b1;
        cycles(1);
        flag_a_clr = 1'b0;
        check(!flag_a, "R9 write-one clears", flag_a, 0);
        move_a(1'b1, 1);
        check(flag_a, "R9 set wins over clear", flag_a, 1);
        check(reg_a == 16'd21 && reg_c == 16'd21, "R4 repeat capture",
              {reg_a, reg_c}, {16'd21, 16'd21});
    endtask

    task automatic t_clear_b();
        edge_sel_b = 2'b01;
        cap_b_in = 1'b1;
        cycles(3);
        check(count == 16'd21 && !flag_b, "R7 rising on B ignored", count, 21);
        cnt_tick = 1'b1;
        cap_b_in = 1'b0;
        cycles(3);
        check(count == 16'd0, "R5 clear beats tick", count, 0);
        check(flag_b, "R9 flag B set", flag_b, 1);
        cycles(1);
        cnt_tick = 1'b0;
        check(count == 16'd1, "R2 counts after clear", count, 1);
        flag_b_clr = 1'b1;
        cycles(1);
        flag_b_clr = 1'b0;
        check(!flag_b, "R9 flag B cleared", flag_b, 0);
    endtask

    task automatic t_joint();
        run_ticks(6);
        edge_sel_a = 2'b10; edge_sel_b = 2'b10;
        cap_a_in = 1'b0; cap_b_in = 1'b1;
        cycles(3);
        check(reg_a == 16'd7 && count == 16'd0, "R6 joint capture",
              {reg_a, count}, {16'd7, 16'd0});
        check(reg_c == 16'd21, "R6 buffer shift", reg_c, 21);
    endtask

    task automatic t_wrap();
        do_reset();
        run_ticks(65535);
        check(count == 16'hFFFF && !ovf_flag, "R3 full scale", count, 16'hFFFF);
        run_ticks(1);
        check(count == 16'd0 && ovf_flag, "R3 wrap sets flag", {count, 15'd0, ovf_flag}, 1);
        cycles(3);
        check(ovf_flag, "R3 flag sticky", ovf_flag, 1);
        ovf_clr = 1'b1;
        cycles(1);
        ovf_clr = 1'b0;
        check(!ovf_flag, "R3 flag cleared", ovf_flag, 0);
    endtask

    initial begin
        t_reset();
        t_count();
        t_latency();
        t_edge_select();
        t_flags();
        t_clear_b();
        t_joint();
        t_wrap();
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule